// File: doc/BRIEF.md
# Watchdog Timer with Strap-Selected Write Protection

This block is a watchdog timer. It counts slow ticks from a separate watchdog clock source, which reach the bus-clock domain as a one-cycle tick-enable. If software does not restart it before the selected period runs out, it raises a one-cycle system reset request. A 3-bit period select picks one of eight timeouts. Each timeout is a power of two of ticks. A restart pulse, a disabled watchdog and a chip reset all return the count to zero.

A static safety strap sets how the watchdog comes out of reset. The strap also decides whether software may ever switch the watchdog off. With the strap low (relaxed), the watchdog starts disabled. With the strap high (strict), it starts enabled and stays enabled. In both modes, changing the period or clearing the enable needs a two-write unlock. The first write sets the change bit and the enable bit together, which opens a short window. A second write inside that window, with the change bit clear, commits the new values.

Top module: `wdt_guard`

## Requirements
- R1: The count advances only in cycles where `wd_tick` is high. With ticks on every other cycle, the timeout takes twice as many bus cycles.
- R2: With select value n on `period_sel`, the request fires on the 2^(BASE_EXP+n)-th tick after the count was last cleared. BASE_EXP defaults to 11. All eight values of n from 0 to 7 are supported.
- R3: `kick` clears the count. When `kick` falls in the same cycle as the tick that would end the period, no request is made, and the next period starts from zero.
- R4: While the watchdog is off, the count is held at zero and no request is raised. After it is switched on, a full period elapses before the first request.
- R5: `sys_rst_req` is high for exactly one bus cycle per expiry. The count then restarts from zero, so the next request follows one full period later if there is no kick.
- R6: After chip reset, `wd_on` equals `strict_mode` (0 in relaxed mode, 1 in strict mode), `period_sel` is 0, `chg_open` is 0 and `sys_rst_req` is 0.
- R7: A write with `cfg_chg`=1 and `cfg_en`=1 opens the unlock window. `chg_open` is then high for the 4 cycles after that write and clears by itself unless a commit closes it first.
- R8: A write with `cfg_chg`=0 while `chg_open` is high loads both `cfg_en` and `cfg_sel`, then closes the window. Outside the window, such a write leaves `period_sel` unchanged and cannot clear `wd_on`. A write with `cfg_en`=1 always switches the watchdog on.
- R9: In strict mode, `wd_on` stays 1 even after a disable is committed inside a valid window. The period can still be changed through the window.
- R10: A write with `cfg_chg`=1 and `cfg_en`=0 does not open the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Chip reset, synchronous, active low |
| wd_tick | input | 1 | One-cycle tick from the watchdog clock source |
| kick | input | 1 | Restart pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Written enable value |
| cfg_chg | input | 1 | Written change-enable value |
| cfg_sel | input | 3 | Written period select |
| strict_mode | input | 1 | Static safety strap: 0 relaxed, 1 strict |
| sys_rst_req | output | 1 | One-cycle system reset request |
| wd_on | output | 1 | Effective enable state |
| chg_open | output | 1 | Unlock window is open |
| period_sel | output | 3 | Active period select |

## Verification
A restart and the final tick of a period can land on the same bus edge. The restart must win, and the expiry must then move one whole period later. The bench provokes this by issuing `kick` exactly one period after a previous kick, with ticks on every cycle. It then requires that no request appears at that edge and that one appears a full period afterwards. A second collision is a commit write that arrives on the edge where the window would expire. The bench probes this by committing on the fourth and on the fifth cycle after opening, and it judges the outcome by `wd_on` and `period_sel`.

// File: rtl/wdt_guard_pkg.sv
// Package: shared widths and the configuration write record for the
// watchdog. Assumes a 3-bit period select, giving eight periods.
package wdt_guard_pkg;

    parameter int WDG_SEL_W = 3;

    typedef logic [WDG_SEL_W-1:0] wdg_sel_t;

    // One configuration write as seen by the protection sequencer.
    typedef struct packed {
        logic     we;
        logic     en;
        logic     chg;
        wdg_sel_t sel;
    } wdg_cfg_t;

endpackage

// File: rtl/wdt_unlock.sv
// Module: write-protection sequencer. Holds the enable and the period
// select, and only lets them change through an open-then-commit sequence.
// Assumes the strap is static and that rst_n is synchronous and active low.
module wdt_unlock
    import wdt_guard_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     strict,
    input  wdg_cfg_t cfg,
    output logic     en_eff,
    output wdg_sel_t sel_q,
    output logic     win_open
);

    localparam int WIN_W = $clog2(WIN_CYC + 1);

    logic             en_q;
    logic [WIN_W-1:0] win_cnt;
    logic             open_wr;
    logic             commit_wr;

    // Decode the write type: one that opens the window, or one that commits.
    always_comb begin
        open_wr   = cfg.we && cfg.chg && cfg.en;
        commit_wr = cfg.we && !cfg.chg && (win_cnt != '0);
    end

    // Enable and select registers, plus the countdown of the unlock window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= strict;
            sel_q   <= '0;
            win_cnt <= '0;
        end else if (commit_wr) begin
            en_q    <= cfg.en | strict;
            sel_q   <= cfg.sel;
            win_cnt <= '0;
        end else begin
            if (cfg.we && cfg.en) begin
                en_q <= 1'b1;
            end
            if (open_wr) begin
                win_cnt <= WIN_W'(WIN_CYC);
            end else if (win_cnt != '0) begin
                win_cnt <= win_cnt - 1'b1;
            end
        end
    end

    // The strap overrides the register so strict mode can never read as off.
    always_comb begin
        en_eff   = en_q | strict;
        win_open = (win_cnt != '0);
    end

endmodule

// File: rtl/wdt_count.sv
// Module: tick-driven timeout counter with period decode and expiry pulse.
// Assumes the tick is already a one-cycle enable in the bus clock domain.
module wdt_count
    import wdt_guard_pkg::*;
#(
    parameter int BASE_EXP = 11
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     kick,
    input  logic     en,
    input  wdg_sel_t sel,
    output logic     expire
);

    localparam int NSEL  = 2 ** WDG_SEL_W;
    localparam int CNT_W = BASE_EXP + NSEL - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_tab [NSEL];
    logic [CNT_W-1:0] last_sel;
    logic             hit;

    // One entry per select value: the last count value of that period.
    for (genvar g = 0; g < NSEL; g++) begin : g_last
        assign last_tab[g] = CNT_W'((64'(1) << (BASE_EXP + g)) - 64'(1));
    end

    // Choose the active limit and detect the expiring tick. >= also catches
    // a switch to a shorter period.
    always_comb begin
        last_sel = last_tab[sel];
        hit      = en && tick && !kick && (cnt >= last_sel);
    end

    // Count register: cleared by kick, disable or expiry, and advanced on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (kick || !en || hit) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Registered one-cycle expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expire <= 1'b0;
        end else begin
            expire <= hit;
        end
    end

endmodule

// File: rtl/wdt_guard.sv
// Module: top of the watchdog. Joins the write-protection sequencer with
// the timeout counter. Assumes synchronous active-low chip reset and a
// strict_mode strap that changes only while reset is held.
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int BASE_EXP = 11,
    parameter int WIN_CYC  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_tick,
    input  logic       kick,
    input  logic       cfg_we,
    input  logic       cfg_en,
    input  logic       cfg_chg,
    input  logic [2:0] cfg_sel,
    input  logic       strict_mode,
    output logic       sys_rst_req,
    output logic       wd_on,
    output logic       chg_open,
    output logic [2:0] period_sel
);

    wdg_cfg_t cfg_w;
    wdg_sel_t sel_w;

    // Pack the write port into the shared record.
    always_comb begin
        cfg_w.we  = cfg_we;
        cfg_w.en  = cfg_en;
        cfg_w.chg = cfg_chg;
        cfg_w.sel = cfg_sel;
    end

    wdt_unlock #(
        .WIN_CYC (WIN_CYC)
    ) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .strict   (strict_mode),
        .cfg      (cfg_w),
        .en_eff   (wd_on),
        .sel_q    (sel_w),
        .win_open (chg_open)
    );

    wdt_count #(
        .BASE_EXP (BASE_EXP)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (wd_tick),
        .kick   (kick),
        .en     (wd_on),
        .sel    (sel_w),
        .expire (sys_rst_req)
    );

    // Bring the active select out to the port.
    always_comb begin
        period_sel = sel_w;
    end

endmodule

// File: rtl/wdt_guard_chk.sv
// Checker: temporal properties of the watchdog, observed at its ports.
// Bound into every instance of wdt_guard.
module wdt_guard_chk #(
    parameter int WIN_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wd_tick,
    input logic       kick,
    input logic       cfg_we,
    input logic       strict_mode,
    input logic       sys_rst_req,
    input logic       wd_on,
    input logic       chg_open,
    input logic [2:0] period_sel
);

    int unsigned open_run;

    // Track how many cycles in a row the window has stayed open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_run <= 0;
        end else if (chg_open) begin
            open_run <= open_run + 1;
        end else begin
            open_run <= 0;
        end
    end

    AST_NO_TICK_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_tick |=> !sys_rst_req);                                    // R1
    AST_KICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !sys_rst_req);                                        // R3
    AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_on |=> !sys_rst_req);                                      // R4
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);                                 // R5
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        open_run <= WIN_CYC);                                          // R7
    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && chg_open) |=> $stable(period_sel));                // R8
    AST_NO_DISABLE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_on && !chg_open) |=> wd_on);                               // R8
    AST_STRICT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        strict_mode |-> wd_on);                                        // R9

endmodule

bind wdt_guard wdt_guard_chk #(
    .WIN_CYC (WIN_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wd_tick     (wd_tick),
    .kick        (kick),
    .cfg_we      (cfg_we),
    .strict_mode (strict_mode),
    .sys_rst_req (sys_rst_req),
    .wd_on       (wd_on),
    .chg_open    (chg_open),
    .period_sel  (period_sel)
);

// File: tb/wdt_guard_tb.sv
// Scoreboard bench: driver tasks push the expected request cycles, and a
// monitor pops and compares them whenever the design raises a request.
module wdt_guard_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 4;
    localparam int WIN        = 4;

    typedef struct {
        int    at;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wd_tick;
    logic       kick;
    logic       cfg_we;
    logic       cfg_en;
    logic       cfg_chg;
    logic [2:0] cfg_sel;
    logic       strict_mode;
    logic       sys_rst_req;
    logic       wd_on;
    logic       chg_open;
    logic [2:0] period_sel;

    int   cyc   = 0;
    logic slow  = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done  = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    assign wd_tick = slow ? cyc[0] : 1'b1;

    wdt_guard #(
        .BASE_EXP (BASE),
        .WIN_CYC  (WIN)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wd_tick     (wd_tick),
        .kick        (kick),
        .cfg_we      (cfg_we),
        .cfg_en      (cfg_en),
        .cfg_chg     (cfg_chg),
        .cfg_sel     (cfg_sel),
        .strict_mode (strict_mode),
        .sys_rst_req (sys_rst_req),
        .wd_on       (wd_on),
        .chg_open    (chg_open),
        .period_sel  (period_sel)
    );

    function automatic int period(int n);
        return 1 << (BASE + n);
    endfunction

    task automatic chk(string req, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: every request must match the next expected cycle.
    always @(negedge clk) begin
        if (rst_n && sys_rst_req) begin
            if (exp_q.size() == 0) begin
                chk("R2", "unexpected request at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "request cycle", cyc, e.at);
            end
        end
    end

    task automatic wr(bit en, bit chg, logic [2:0] sel);
        cfg_we = 1'b1; cfg_en = en; cfg_chg = chg; cfg_sel = sel;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic unlock(bit en, logic [2:0] sel);
        wr(1'b1, 1'b1, 3'd0);
        wr(en, 1'b0, sel);
    endtask

    task automatic kick_exp(int t, string tag);
        kick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        kick = 1'b0;
        if (t > 0) exp_q.push_back('{cyc + t, tag});
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(bit s, int t, string tag);
        exp_q.delete();
        rst_n = 1'b0;
        strict_mode = s;
        idle(3);
        rst_n = 1'b1;
        if (t > 0) exp_q.push_back('{cyc + t, tag});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        int k0;
        rst_n = 1'b0; kick = 1'b0; cfg_we = 1'b0; cfg_en = 1'b0;
        cfg_chg = 1'b0; cfg_sel = 3'd0; strict_mode = 1'b0;
        @(negedge clk);

        // ---------------- relaxed mode ----------------
        do_reset(1'b0, 0, "");
        chk("R6", "wd_on after reset (relaxed)", wd_on, 0);
        chk("R6", "period_sel after reset", period_sel, 0);
        chk("R6", "chg_open after reset", chg_open, 0);
        chk("R6", "request after reset", sys_rst_req, 0);
        idle(40);                                   // R4: off, no request

        wr(1'b1, 1'b0, 3'd5);                       // free enable, select locked
        chk("R8", "plain write enables", wd_on, 1);
        chk("R8", "plain write leaves select", period_sel, 0);
        kick_exp(period(0), "R2");
        exp_q.push_back('{cyc + 2 * period(0), "R5"}); // automatic restart
        idle(2 * period(0) + 2);

        for (int n = 0; n < 8; n++) begin
            unlock(1'b1, 3'(n));
            chk("R8", "committed select", period_sel, n);
            kick_exp(period(n), "R2");
            idle(period(n) + 2);
        end

        // Late commit is ignored; window length probed.
        unlock(1'b1, 3'd0);
        kick_exp(period(0), "R8");
        wr(1'b1, 1'b1, 3'd0);
        chk("R7", "window open after opening write", chg_open, 1);
        idle(3);
        chk("R7", "window still open on 4th cycle", chg_open, 1);
        idle(1);
        chk("R7", "window closed after 4 cycles", chg_open, 0);
        wr(1'b0, 1'b0, 3'd3);
        chk("R8", "late commit cannot disable", wd_on, 1);
        chk("R8", "late commit cannot change select", period_sel, 0);
        idle(12);

        // Commit on the last open cycle is accepted.
        wr(1'b1, 1'b1, 3'd0);
        idle(3);
        wr(1'b1, 1'b0, 3'd1);
        chk("R8", "commit on last window cycle", period_sel, 1);
        unlock(1'b1, 3'd0);
        kick_exp(0, "");

        // Kick on the final tick wins.
        idle(period(0) - 1);
        kick_exp(period(0), "R3");
        idle(period(0) + 2);

        // Half-rate ticks double the timeout.
        slow = 1'b1;
        kick_exp(0, "");
        k0 = cyc;
        exp_q.push_back('{k0 + 2 * period(0) - (k0 & 1), "R1"});
        idle(2 * period(0) + 2);
        slow = 1'b0;

        // Timed disable, then a non-opening change write.
        unlock(1'b0, 3'd0);
        chk("R8", "timed disable", wd_on, 0);
        wr(1'b0, 1'b1, 3'd0);
        chk("R10", "change write without enable keeps window shut", chg_open, 0);
        idle(60);
        chk("R4", "stays off", wd_on, 0);
        wr(1'b1, 1'b0, 3'd0);
        exp_q.push_back('{cyc + period(0), "R4"});
        idle(period(0) + 2);

        // ---------------- strict mode ----------------
        do_reset(1'b1, period(0), "R6");
        chk("R6", "wd_on after reset (strict)", wd_on, 1);
        chk("R6", "period_sel after reset (strict)", period_sel, 0);
        idle(period(0) + 2);

        wr(1'b0, 1'b0, 3'd6);
        chk("R9", "plain disable ignored (strict)", wd_on, 1);
        chk("R8", "plain select ignored (strict)", period_sel, 0);
        unlock(1'b0, 3'd2);
        chk("R9", "timed disable ignored (strict)", wd_on, 1);
        chk("R9", "timed period change (strict)", period_sel, 2);
        kick_exp(period(2), "R9");
        idle(period(2) + 2);

        for (int n = 0; n < 8; n++) begin
            unlock(1'b1, 3'(n));
            chk("R9", "strict committed select", period_sel, n);
            kick_exp(period(n), "R2");
            idle(period(n) + 2);
        end

        idle(4);
        chk("R2", "all expected requests seen", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule